// File: doc/BRIEF.md
# Quotient Digit Estimator

This block supplies the quotient-digit step of a floating-point divider. It takes a double-width dividend, given as a high word and a low word, and a normalised divisor whose top bit is set. It returns a single-word estimate of the quotient. The estimate is never below the truncated exact quotient and never more than two above it. A caller then applies its own exact-remainder fix-up to that estimate.

The estimate is built as two half-word digits. Each digit comes from dividing by the upper half of the divisor only, and a small sequential restoring divider does that division. After the upper digit is found, a trial remainder is formed at full double width. While that remainder is negative, the upper digit is stepped down by one and the shifted divisor is added back. The lower digit is then taken from the middle of the corrected remainder. There are two saturating shortcuts. When the quotient cannot fit in one word, the result is all ones at once. When a digit cannot fit in a half word, that digit becomes all ones.

Top module: `qde_estimator`

## Requirements
- R1: A start that is accepted while `dvsr` is less than or equal to `num_hi` returns `quot` = all ones, with `done` high in the cycle right after the start. The caller keeps `dvsr[63]` = 1 on every accepted start.
- R2: Without saturation, the upper 32 bits of the estimate are `num_hi / dvsr[63:32]`, less one for each correction step.
- R3: When `{dvsr[63:32], 32'h0}` is less than or equal to `num_hi`, the upper digit starts at 0xFFFFFFFF.
- R4: The trial remainder is `{num_hi,num_lo}` minus `dvsr` times the upper digit placed at bit 32, computed over 128 bits. While bit 127 of that remainder is set, each clock subtracts one from the upper digit and adds `dvsr` shifted left by 32 to the remainder.
- R5: The lower 32 bits of the estimate are bits 95:32 of the corrected remainder divided by `dvsr[63:32]`. They are 0xFFFFFFFF when those 64 bits are at least `{dvsr[63:32], 32'h0}`.
- R6: When `num_hi` < `dvsr`, the estimate q satisfies t <= q <= t+2, where t is the truncated value of `{num_hi,num_lo}/dvsr`.
- R7: `done` is a one-cycle pulse raised in the cycle after the final step. `busy` is high from the cycle after an accepted non-saturating start until `done` rises, and `busy` is never high at the same time as `done`.
- R8: A start received while `busy` is high is ignored: no extra `done` appears, and neither `quot` nor the result in progress is altered.
- R9: A start raised in the same cycle that `done` is high is accepted.
- R10: After reset, `done`, `busy` and `quot` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an estimate; sampled only when idle |
| num_hi | input | 64 | Dividend upper word |
| num_lo | input | 64 | Dividend lower word |
| dvsr | input | 64 | Divisor, bit 63 set |
| quot | output | 64 | Quotient estimate, valid while done is high and held afterwards |
| done | output | 1 | One-cycle result pulse |
| busy | output | 1 | An estimate is in progress |

## Verification
Finishing one estimate and accepting the next can fall in the same cycle. In the cycle where `done` is high the unit is already idle, so a new `start` may arrive there. The driver provokes this on every operation by starting the next one at the first idle sample, which is often the `done` sample itself. The saturating shortcut makes the overlap sharper: it can produce `done` pulses on consecutive cycles. A stray or lost completion shows up in the scoreboard as an unmatched pulse or a wrong value, and an ignored start issued mid-operation shows up the same way.

// File: rtl/qde_pkg.sv
// Shared definitions for the quotient digit estimator.
// Assumes nothing beyond a single clock domain.
package qde_pkg;

    // Sequencer states of the estimator
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HI      = 3'd1,
        ST_HI_WAIT = 3'd2,
        ST_REM     = 3'd3,
        ST_FIX     = 3'd4,
        ST_LO      = 3'd5,
        ST_LO_WAIT = 3'd6
    } qde_state_e;

endpackage

// File: rtl/qde_halfdiv.sv
// Sequential restoring divider: a W-bit numerator divided by an H-bit
// denominator (H = W/2), one quotient bit per clock, H clocks per divide.
// Assumes the upper half of the numerator is below the denominator, so the
// quotient fits in H bits. fin pulses for one cycle when quo becomes valid.
module qde_halfdiv #(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [W-1:0]     num,
    input  logic [W/2-1:0]   den,
    output logic [W/2-1:0]   quo,
    output logic             fin
);
    localparam int H  = W / 2;
    localparam int CW = $clog2(H + 1);

    logic [H-1:0]  part_q;
    logic [H-1:0]  bits_q;
    logic [H-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [H:0]    trial;
    logic          take;

    // Shift the next numerator bit into the partial remainder and compare
    always_comb begin
        trial = {part_q, bits_q[H-1]};
        take  = (trial >= {1'b0, den_q});
    end

    // One restoring step per clock; the quotient bits replace the numerator bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            bits_q <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !run_q) begin
                part_q <= num[W-1:H];
                bits_q <= num[H-1:0];
                den_q  <= den;
                cnt_q  <= CW'(H);
                run_q  <= 1'b1;
            end else if (run_q) begin
                part_q <= take ? H'(trial - {1'b0, den_q}) : trial[H-1:0];
                bits_q <= {bits_q[H-2:0], take};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quo = bits_q;

endmodule

// File: rtl/qde_digit_sat.sv
// Saturation test for one quotient digit: flags when the numerator is at
// least the denominator half placed in the upper half, i.e. the digit would
// not fit in H bits. Purely combinational.
module qde_digit_sat #(
    parameter int W = 64
) (
    input  logic [W-1:0]   num,
    input  logic [W/2-1:0] den_hi,
    output logic           sat
);
    localparam int H = W / 2;

    // Compare against the denominator half shifted up by H
    always_comb begin
        sat = ({den_hi, {H{1'b0}}} <= num);
    end

endmodule

// File: rtl/qde_remainder.sv
// Double-width remainder arithmetic for the estimator: forms the trial
// remainder dividend - divisor * (digit << H), and the restoring step
// remainder + (divisor << H). Both results are modulo 2^(2W).
module qde_remainder #(
    parameter int W = 64
) (
    input  logic [W-1:0]   a_hi,
    input  logic [W-1:0]   a_lo,
    input  logic [W-1:0]   dv,
    input  logic [W/2-1:0] digit,
    input  logic [2*W-1:0] rem_in,
    output logic [2*W-1:0] rem_trial,
    output logic [2*W-1:0] rem_fixed
);
    localparam int H  = W / 2;
    localparam int DW = 2 * W;

    logic [DW-1:0] prod;
    logic [DW-1:0] dv_up;

    // Divisor times digit, then aligned to the upper digit position
    always_comb begin
        prod      = {{W{1'b0}}, dv} * {{(W + H){1'b0}}, digit};
        rem_trial = {a_hi, a_lo} - (prod << H);
    end

    // Add back the divisor shifted by H for one correction step
    always_comb begin
        dv_up     = {{H{1'b0}}, dv, {H{1'b0}}};
        rem_fixed = rem_in + dv_up;
    end

endmodule

// File: rtl/qde_estimator.sv
// Quotient digit estimator: estimates {num_hi,num_lo} / dvsr to within +2
// of the truncated quotient. The divisor must have its top bit set.
// Sequence: overflow shortcut, upper digit (saturate or divide), trial
// remainder, one correction per clock while negative, lower digit.
// Starts are only sampled in the idle state.
module qde_estimator #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] quot,
    output logic         done,
    output logic         busy
);
    import qde_pkg::*;

    localparam int H  = W / 2;
    localparam int DW = 2 * W;

    qde_state_e     state_q;
    logic [W-1:0]   a_hi_q;
    logic [W-1:0]   a_lo_q;
    logic [W-1:0]   dv_q;
    logic [H-1:0]   zhi_q;
    logic [DW-1:0]  rem_q;
    logic [W-1:0]   quot_q;
    logic           done_q;

    logic [W-1:0]   mid;
    logic [W-1:0]   sat_num;
    logic           sat;
    logic           div_go;
    logic [H-1:0]   div_quo;
    logic           div_fin;
    logic [DW-1:0]  rem_trial;
    logic [DW-1:0]  rem_fixed;
    logic           ovf_now;

    // Middle word of the corrected remainder feeds the lower digit
    always_comb begin
        mid     = rem_q[W+H-1:H];
        sat_num = (state_q == ST_LO) ? mid : a_hi_q;
        div_go  = ((state_q == ST_HI) || (state_q == ST_LO)) && !sat;
        ovf_now = (dvsr <= num_hi);
    end

    qde_digit_sat #(.W(W)) sat_i (
        .num    (sat_num),
        .den_hi (dv_q[W-1:H]),
        .sat    (sat)
    );

    qde_halfdiv #(.W(W)) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (sat_num),
        .den  (dv_q[W-1:H]),
        .quo  (div_quo),
        .fin  (div_fin)
    );

    qde_remainder #(.W(W)) rem_i (
        .a_hi      (a_hi_q),
        .a_lo      (a_lo_q),
        .dv        (dv_q),
        .digit     (zhi_q),
        .rem_in    (rem_q),
        .rem_trial (rem_trial),
        .rem_fixed (rem_fixed)
    );

    // Main sequencer: walks the estimate steps and registers the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            a_hi_q  <= '0;
            a_lo_q  <= '0;
            dv_q    <= '0;
            zhi_q   <= '0;
            rem_q   <= '0;
            quot_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (ovf_now) begin
                            quot_q <= '1;
                            done_q <= 1'b1;
                        end else begin
                            a_hi_q  <= num_hi;
                            a_lo_q  <= num_lo;
                            dv_q    <= dvsr;
                            state_q <= ST_HI;
                        end
                    end
                end
                ST_HI: begin
                    if (sat) begin
                        zhi_q   <= '1;
                        state_q <= ST_REM;
                    end else begin
                        state_q <= ST_HI_WAIT;
                    end
                end
                ST_HI_WAIT: begin
                    if (div_fin) begin
                        zhi_q   <= div_quo;
                        state_q <= ST_REM;
                    end
                end
                ST_REM: begin
                    rem_q   <= rem_trial;
                    state_q <= ST_FIX;
                end
                ST_FIX: begin
                    if (rem_q[DW-1]) begin
                        rem_q <= rem_fixed;
                        zhi_q <= zhi_q - 1'b1;
                    end else begin
                        state_q <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (sat) begin
                        quot_q  <= {zhi_q, {H{1'b1}}};
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_LO_WAIT;
                    end
                end
                ST_LO_WAIT: begin
                    if (div_fin) begin
                        quot_q  <= {zhi_q, div_quo};
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign quot = quot_q;
    assign done = done_q;
    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/qde_estimator_chk.sv
// Port-level protocol checks for qde_estimator, attached with bind.
module qde_estimator_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] num_hi,
    input logic [W-1:0] num_lo,
    input logic [W-1:0] dvsr,
    input logic [W-1:0] quot,
    input logic         done,
    input logic         busy
);
    // R1
    ovf_shortcut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && dvsr <= num_hi) |=> (done && quot == {W{1'b1}}));

    // R1
    dvsr_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> dvsr[W-1]);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    hold_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(quot));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && dvsr > num_hi) |=> busy);

endmodule

bind qde_estimator qde_estimator_chk #(.W(W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .num_hi(num_hi),
    .num_lo(num_lo),
    .dvsr  (dvsr),
    .quot  (quot),
    .done  (done),
    .busy  (busy)
);

// File: tb/qde_estimator_tb_top.sv
module qde_estimator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] num_hi = '0;
    logic [63:0] num_lo = '0;
    logic [63:0] dvsr = 64'h8000_0000_0000_0000;
    logic [63:0] quot;
    logic        done;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_sent = 0;
    int n_done = 0;
    bit ended  = 0;

    logic [63:0] q_exp[$];
    logic [63:0] q_hi[$];
    logic [63:0] q_lo[$];
    logic [63:0] q_d[$];
    string       q_tag[$];
    int          q_cyc[$];

    always #5 clk = ~clk;

    qde_estimator dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .num_hi(num_hi), .num_lo(num_lo), .dvsr(dvsr),
        .quot(quot), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected estimate from the requirements, at 128-bit width
    function automatic logic [63:0] model(input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] d);
        logic [127:0] r;
        logic [63:0]  z;
        logic [63:0]  m;
        logic [63:0]  b0;
        if (d <= hi) return 64'hFFFF_FFFF_FFFF_FFFF;
        b0 = {32'h0, d[63:32]};
        if ((b0 << 32) <= hi) z = 64'hFFFF_FFFF_0000_0000;
        else z = (hi / b0) << 32;
        r = {hi, lo} - ({64'h0, d} * {64'h0, z});
        while (r[127]) begin
            z = z - 64'h1_0000_0000;
            r = r + {32'h0, d, 32'h0};
        end
        m = r[95:32];
        if ((b0 << 32) <= m) z = z | 64'hFFFF_FFFF;
        else z = z | (m / b0);
        return z;
    endfunction

    // Driver: waits for idle, issues one start, pushes the expected item
    task automatic send(input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] d, input string tag);
        while (busy) @(negedge clk);
        num_hi = hi; num_lo = lo; dvsr = d; start = 1'b1;
        q_exp.push_back(model(hi, lo, d));
        q_hi.push_back(hi); q_lo.push_back(lo); q_d.push_back(d);
        q_tag.push_back(tag); q_cyc.push_back(cyc);
        n_sent++;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Start pulse while busy: must be ignored (R8)
    task automatic poke(input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] d);
        num_hi = hi; num_lo = lo; dvsr = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops the scoreboard on each done and compares
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (q_exp.size() == 0) begin
                chk(1'b0, "R8 unexpected done", quot, 64'h0);
            end else begin
                logic [63:0]  e, h, l, d;
                logic [127:0] t;
                string        tg;
                int           c;
                e = q_exp.pop_front(); h = q_hi.pop_front(); l = q_lo.pop_front();
                d = q_d.pop_front(); tg = q_tag.pop_front(); c = q_cyc.pop_front();
                chk(quot == e, tg, quot, e);
                if (d <= h) begin
                    // R1 latency: done right after the accepting edge
                    chk(cyc == c + 1, "R1 latency", 64'(cyc), 64'(c + 1));
                end else begin
                    // R6 bound against the exact quotient
                    t = {h, l} / {64'h0, d};
                    chk(({64'h0, quot} >= t) && ({64'h0, quot} <= t + 2), "R6 bound", quot, t[63:0]);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 150000 && !ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(done == 1'b0, "R10 done", 64'(done), 64'h0);
        chk(busy == 1'b0, "R10 busy", 64'(busy), 64'h0);
        chk(quot == 64'h0, "R10 quot", quot, 64'h0);

        // R1 overflow shortcut, strictly greater and equal
        send(64'h9000_0000_0000_0000, 64'h1234, 64'h8000_0000_0000_0001, "R1 ovf");
        send(64'hC000_0000_0000_0005, 64'h0, 64'hC000_0000_0000_0005, "R1 ovf equal");
        // R9: back-to-back overflow then normal started on the done cycle
        send(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h8000_0000_0000_0000, "R2 plain digit");
        // R3 upper digit saturation
        send(64'hFFFF_FFFF_4000_0000, 64'h0, 64'hFFFF_FFFF_8000_0000, "R3 hi saturate");
        // R4 correction steps
        send(64'h7FFF_FFFF_0000_0000, 64'h0, 64'h8000_0000_FFFF_FFFF, "R4 correction");
        send(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_FFFF_FFFF, "R4 correction max");
        // R5 lower digit
        send(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R5 lo digit");
        send(64'hFFFF_FFFE_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, "R5 lo near sat");

        // R8 ignored start while busy
        send(64'h0123_4567_89AB_CDEF, 64'h5555_AAAA_5555_AAAA, 64'hA000_0000_1234_5678, "R8 first");
        poke(64'h7000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000);
        poke(64'hF000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000);

        for (int i = 0; i < 24; i++) begin
            logic [63:0] d, h, l;
            d = {1'b1, 31'($urandom), 32'($urandom)};
            l = {32'($urandom), 32'($urandom)};
            if (i % 3 == 0) h = d - 64'($urandom % 1000) - 1;
            else h = {1'b0, 31'($urandom), 32'($urandom)};
            if (i % 8 == 7) h = d;
            send(h, l, d, "R6 random");
        end

        while (busy || q_exp.size() != 0) @(negedge clk);
        repeat (120) @(negedge clk);
        // R8: one done per accepted start, no strays
        chk(n_done == n_sent, "R8 done count", 64'(n_done), 64'(n_sent));
        chk(q_exp.size() == 0, "R7 scoreboard drained", 64'(q_exp.size()), 64'h0);
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule